// File: doc/BRIEF.md
# Vector Lane Compaction Unit

This block accepts one vector of sixteen 32-bit lanes together with a 16-bit lane-select word. It moves every selected lane into a dense run that starts at result position 0. Selected lanes keep their order, unselected lanes are dropped, and every result position past the run is cleared to zero. Next to the packed vector it gives the number of selected lanes, so a following store stage can advance its write pointer by exactly that amount.

Each selected lane's destination is the number of selected lanes below it, which is an exclusive prefix population count of the select word. A routing network then steers each lane to that destination. Both the input and the output use a valid/ready handshake. A single output register gives one cycle of latency, and the register can take a new vector in the same cycle that it hands the old one on.

Top module: `vcompress_unit`

## Requirements
- R1: A lane whose select bit is 1 (bit i of `in_sel` governs lane i, which is `in_vec[32*i+31:32*i]`) appears in the result; a lane whose bit is 0 does not. The selected lanes fill result positions 0, 1, 2 and onward with no gaps.
- R2: Order is preserved. A selected lane with a lower index always lands at a lower result position than a selected lane with a higher index. Result position k is `out_vec[32*k+31:32*k]`.
- R3: Every result position k with k greater than or equal to `out_cnt` holds zero.
- R4: `out_cnt` equals the number of 1 bits in the accepted select word, in the range 0 to 16.
- R5: A select word of all zeros gives `out_cnt` = 0 and an all-zero result vector.
- R6: A select word of all ones gives the input vector unchanged, with `out_cnt` = 16.
- R7: A vector is accepted on a rising edge where `in_valid` and `in_rdy` are both 1. Its result is shown with `out_valid` = 1 from the very next edge on.
- R8: While `out_valid` is 1 and `out_rdy` is 0, `out_vec` and `out_cnt` keep their values and `in_rdy` is 0.
- R9: While `out_rdy` stays 1, one vector is accepted on every clock edge. No result is lost or duplicated, and results leave in the order their vectors were accepted.
- R10: During and right after reset (`rst_n` low), `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input vector and select word are valid |
| in_rdy | output | 1 | Unit can take an input this cycle |
| in_vec | input | 512 | Sixteen 32-bit lanes, lane 0 in the low bits |
| in_sel | input | 16 | One select bit per lane |
| out_valid | output | 1 | Result register holds a result |
| out_rdy | input | 1 | Consumer takes the result this cycle |
| out_vec | output | 512 | Packed result, position 0 in the low bits |
| out_cnt | output | 5 | Number of selected lanes |

## Verification
Draining a held result and loading a new vector can happen on the same clock edge. That is the point where a wrong in-ready term would either drop a result or hand one out twice. The bench provokes this edge by keeping the consumer ready while the driver sends vectors back to back, and again while the consumer's ready signal toggles at random. A scoreboard judges the outcome: every result must match, in order, the entry the driver queued from its own compaction model. A directed run also counts the cycles spent on a back-to-back burst, and forced stalls confirm that a held result stays unchanged.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;
   // Default geometry of the compaction unit
   localparam int unsigned VCMP_LANES = 16;
   localparam int unsigned VCMP_EW    = 32;

   // Variants of the prefix-count network
   typedef enum logic [0:0] {
      PFX_RIPPLE = 1'b0,   // one running adder chain across the lanes
      PFX_DIRECT = 1'b1    // an independent popcount per lane
   } pfx_style_e;
endpackage

// File: rtl/vcmp_prefix.sv
module vcmp_prefix
   import vcmp_pkg::*;
#(
   parameter int unsigned LANES = VCMP_LANES,
   parameter pfx_style_e  STYLE = PFX_RIPPLE,
   localparam int unsigned CW   = $clog2(LANES + 1)
) (
   input  logic [LANES-1:0]    sel,
   output logic [LANES*CW-1:0] dest,
   output logic [CW-1:0]       total
);
   if (LANES < 2) begin : g_bad_lanes
      $error("vcmp_prefix: LANES must be at least 2");
   end

   if (STYLE == PFX_RIPPLE) begin : g_ripple
      always_comb begin
         logic [CW-1:0] run;
         run = '0;
         for (int i = 0; i < LANES; i++) begin
            dest[i*CW +: CW] = run;
            run = run + CW'(sel[i]);
         end
         total = run;
      end
   end else begin : g_direct
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         always_comb begin
            logic [CW-1:0] c;
            c = '0;
            for (int j = 0; j < i; j++) c = c + CW'(sel[j]);
            dest[i*CW +: CW] = c;
         end
      end
      always_comb begin
         logic [CW-1:0] t;
         t = '0;
         for (int j = 0; j < LANES; j++) t = t + CW'(sel[j]);
         total = t;
      end
   end
endmodule

// File: rtl/vcmp_route.sv
module vcmp_route
   import vcmp_pkg::*;
#(
   parameter int unsigned LANES = VCMP_LANES,
   parameter int unsigned EW    = VCMP_EW,
   localparam int unsigned CW   = $clog2(LANES + 1),
   localparam int unsigned DW   = LANES * EW
) (
   input  logic [DW-1:0]       vec,
   input  logic [LANES-1:0]    sel,
   input  logic [LANES*CW-1:0] dest,
   output logic [DW-1:0]       packed_vec
);
   if (EW < 1) begin : g_bad_ew
      $error("vcmp_route: EW must be at least 1");
   end

   // Position k can only receive lanes k and above, so the OR tree
   // for position k has LANES-k inputs. Destinations are distinct,
   // which makes a plain OR a correct merge.
   for (genvar k = 0; k < LANES; k++) begin : g_pos
      always_comb begin
         logic [EW-1:0] acc;
         acc = '0;
         for (int i = k; i < LANES; i++) begin
            if (sel[i] && (dest[i*CW +: CW] == CW'(k)))
               acc = acc | vec[i*EW +: EW];
         end
         packed_vec[k*EW +: EW] = acc;
      end
   end
endmodule

// File: rtl/vcmp_stage.sv
module vcmp_stage #(
   parameter int unsigned DW = 512,
   parameter int unsigned CW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   output logic          in_rdy,
   input  logic [DW-1:0] in_vec,
   input  logic [CW-1:0] in_cnt,
   output logic          out_valid,
   input  logic          out_rdy,
   output logic [DW-1:0] out_vec,
   output logic [CW-1:0] out_cnt
);
   logic load;

   assign in_rdy = !out_valid || out_rdy;
   assign load   = in_valid && in_rdy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_vec   <= '0;
         out_cnt   <= '0;
      end else begin
         if (load) begin
            out_valid <= 1'b1;
            out_vec   <= in_vec;
            out_cnt   <= in_cnt;
         end else if (out_rdy) begin
            out_valid <= 1'b0;
         end
      end
   end

   AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_rdy |=> out_valid && $stable(out_vec) && $stable(out_cnt)); // R8
   AST_LOAD_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_rdy |=> out_valid); // R7
   AST_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
      out_rdy |-> in_rdy); // R9
endmodule

// File: rtl/vcompress_unit.sv
module vcompress_unit
   import vcmp_pkg::*;
#(
   parameter int unsigned LANES = VCMP_LANES,
   parameter int unsigned EW    = VCMP_EW,
   parameter pfx_style_e  PFX   = PFX_RIPPLE,
   localparam int unsigned CW   = $clog2(LANES + 1),
   localparam int unsigned DW   = LANES * EW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_rdy,
   input  logic [DW-1:0]    in_vec,
   input  logic [LANES-1:0] in_sel,
   output logic             out_valid,
   input  logic             out_rdy,
   output logic [DW-1:0]    out_vec,
   output logic [CW-1:0]    out_cnt
);
   logic [LANES*CW-1:0] dest;
   logic [CW-1:0]       total;
   logic [DW-1:0]       packed_vec;

   vcmp_prefix #(.LANES(LANES), .STYLE(PFX)) u_prefix (
      .sel   (in_sel),
      .dest  (dest),
      .total (total)
   );

   vcmp_route #(.LANES(LANES), .EW(EW)) u_route (
      .vec        (in_vec),
      .sel        (in_sel),
      .dest       (dest),
      .packed_vec (packed_vec)
   );

   vcmp_stage #(.DW(DW), .CW(CW)) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_rdy    (in_rdy),
      .in_vec    (packed_vec),
      .in_cnt    (total),
      .out_valid (out_valid),
      .out_rdy   (out_rdy),
      .out_vec   (out_vec),
      .out_cnt   (out_cnt)
   );

   AST_CNT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_rdy |=> out_cnt == CW'($countones($past(in_sel)))); // R4
   AST_CNT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_cnt <= CW'(LANES)); // R4
   AST_ZERO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_rdy && (in_sel == '0) |=> out_cnt == '0 && out_vec == '0); // R5
   AST_ALL_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_rdy && (&in_sel) |=> out_vec == $past(in_vec) && out_cnt == CW'(LANES)); // R6
   AST_LOW_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_rdy && in_sel[0] |=> out_vec[EW-1:0] == $past(in_vec[EW-1:0])); // R2
   AST_RESET_IDLE: assert property (@(posedge clk)
      !rst_n |-> !out_valid); // R10

   for (genvar k = 0; k < LANES; k++) begin : g_tail_chk
      AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid && (out_cnt <= CW'(k)) |-> out_vec[k*EW +: EW] == '0); // R3
   end
endmodule

// File: tb/vcompress_unit_tb_top.sv
`timescale 1ns/1ps
module vcompress_unit_tb_top;
   localparam int LANES = 16;
   localparam int EW    = 32;
   localparam int CW    = 5;
   localparam int DW    = LANES * EW;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             in_valid = 1'b0;
   logic             in_rdy;
   logic [DW-1:0]    in_vec = '0;
   logic [LANES-1:0] in_sel = '0;
   logic             out_valid;
   logic             out_rdy = 1'b1;
   logic [DW-1:0]    out_vec;
   logic [CW-1:0]    out_cnt;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int acc_cyc = 0;
   int rdy_mode = 0;  // 0: always ready, 1: random, 2: held low
   logic [DW-1:0] q_vec[$];
   logic [CW-1:0] q_cnt[$];

   vcompress_unit dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_rdy(in_rdy),
      .in_vec(in_vec), .in_sel(in_sel), .out_valid(out_valid),
      .out_rdy(out_rdy), .out_vec(out_vec), .out_cnt(out_cnt)
   );

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Sequential reference: walk lanes low to high, append each selected one
   task automatic model(input logic [DW-1:0] d, input logic [LANES-1:0] m,
                        output logic [DW-1:0] r, output logic [CW-1:0] n);
      int k = 0;
      r = '0;
      for (int i = 0; i < LANES; i++) begin
         if (m[i]) begin
            r[k*EW +: EW] = d[i*EW +: EW];
            k++;
         end
      end
      n = CW'(k);
   endtask

   task automatic send(input logic [DW-1:0] d, input logic [LANES-1:0] m);
      logic [DW-1:0] r;
      logic [CW-1:0] n;
      bit hs;
      model(d, m, r, n);
      q_vec.push_back(r);
      q_cnt.push_back(n);
      @(negedge clk);
      in_valid = 1'b1;
      in_vec = d;
      in_sel = m;
      forever begin
         #1 hs = in_rdy;
         @(posedge clk);
         if (hs) break;
         @(negedge clk);
      end
      #1 acc_cyc = cyc;
   endtask

   task automatic go_idle();
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   function automatic logic [DW-1:0] rand_vec();
      logic [DW-1:0] v;
      for (int i = 0; i < LANES; i++) v[i*EW +: EW] = $urandom;
      return v;
   endfunction

   // Monitor / scoreboard
   initial begin
      bit prev_stall = 1'b0;
      logic [DW-1:0] prev_vec = '0;
      logic [CW-1:0] prev_cnt = '0;
      forever begin
         @(negedge clk);
         case (rdy_mode)
            0: out_rdy = 1'b1;
            1: out_rdy = 1'($urandom % 2);
            default: out_rdy = 1'b0;
         endcase
         #2;
         if (!rst_n) begin
            prev_stall = 1'b0;
            continue;
         end
         if (prev_stall)
            check(out_valid && out_vec == prev_vec && out_cnt == prev_cnt,
                  "R8 held result", out_vec, prev_vec);
         if (out_valid && !out_rdy)
            check(in_rdy == 1'b0, "R8 in_rdy during stall", DW'(in_rdy), '0);
         if (out_valid && out_rdy) begin
            if (q_vec.size() == 0) begin
               check(1'b0, "R9 unexpected result", out_vec, '0);
            end else begin
               logic [DW-1:0] ev;
               logic [CW-1:0] ec;
               ev = q_vec.pop_front();
               ec = q_cnt.pop_front();
               check(out_vec == ev, "R1 R2 R3 packed vector", out_vec, ev);
               check(out_cnt == ec, "R4 count", DW'(out_cnt), DW'(ec));
            end
         end
         prev_stall = out_valid && !out_rdy;
         prev_vec = out_vec;
         prev_cnt = out_cnt;
      end
   end

   // Watchdog
   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [DW-1:0] d;
      int first;
      repeat (3) @(posedge clk);
      #1 check(out_valid == 1'b0, "R10 out_valid in reset", DW'(out_valid), '0);
      @(negedge clk) rst_n = 1'b1;
      #1 check(out_valid == 1'b0, "R10 out_valid after reset", DW'(out_valid), '0);

      // Example-style pattern: lanes 0,3,5,9,12
      d = rand_vec();
      send(d, 16'b0001_0010_0010_1001);
      go_idle();
      #2 check(out_valid == 1'b1, "R7 result one cycle after accept", DW'(out_valid), 1);
      check(out_vec[0*EW +: EW] == d[0*EW +: EW] && out_vec[1*EW +: EW] == d[3*EW +: EW] &&
            out_vec[4*EW +: EW] == d[12*EW +: EW], "R2 order of lanes 0,3,12", out_vec, d);
      check(out_cnt == 5'd5, "R4 count five", DW'(out_cnt), 5);

      // All-zero select
      send(rand_vec(), 16'h0000);
      go_idle();
      #2 check(out_cnt == 0 && out_vec == '0, "R5 empty select", out_vec, '0);

      // All-ones select
      d = rand_vec();
      send(d, 16'hFFFF);
      go_idle();
      #2 check(out_vec == d && out_cnt == 5'd16, "R6 pass through", out_vec, d);

      // Only top lane, only bottom lane
      d = rand_vec();
      send(d, 16'h8000);
      go_idle();
      #2 check(out_vec == DW'(d[15*EW +: EW]) && out_cnt == 1, "R1 top lane to position 0", out_vec, DW'(d[15*EW +: EW]));
      send(rand_vec(), 16'h0001);
      send(rand_vec(), 16'h7FFE);
      go_idle();

      // Stall: hold the output while a second vector waits
      rdy_mode = 2;
      send(rand_vec(), 16'hA5A5);
      @(negedge clk);
      in_valid = 1'b1; in_vec = rand_vec(); in_sel = 16'h5A5A;
      #1 check(in_rdy == 1'b0, "R8 blocked while full", DW'(in_rdy), '0);
      in_valid = 1'b0;
      repeat (4) @(negedge clk);
      rdy_mode = 0;
      repeat (2) @(negedge clk);

      // Back-to-back burst with ready high
      send(rand_vec(), 16'h1234);
      first = acc_cyc;
      for (int i = 0; i < 9; i++) send(rand_vec(), 16'($urandom));
      check(acc_cyc - first == 9, "R9 one accept per cycle", DW'(acc_cyc - first), 9);
      go_idle();

      // Random traffic with random consumer readiness
      rdy_mode = 1;
      for (int i = 0; i < 400; i++) begin
         send(rand_vec(), 16'($urandom));
         if ($urandom % 4 == 0) go_idle();
      end
      go_idle();
      rdy_mode = 0;
      for (int i = 0; i < 2000 && q_vec.size() != 0; i++) @(posedge clk);
      repeat (2) @(posedge clk);
      check(q_vec.size() == 0, "R9 all results drained", DW'(q_vec.size()), '0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule